// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each operation takes the accumulator, a second operand and the incoming carry. The second operand may be an immediate byte, a memory byte or a scratchpad register. The block returns the result byte, a flag telling the datapath whether the accumulator should take that result, and the four flag values the operation produces. All of this is combinational, so a result is available in the same cycle its inputs are presented.

The block also owns the status word. When the update enable is high at a clock edge, the status word takes the new flags, or the interrupt-enable bit is set or cleared. When the enable is low, the status word holds. Fetch, decode and sequencing belong to the surrounding core. That core selects the operation through a 4-bit code and asserts the update enable for exactly one cycle per executed instruction.

Top module: `accalu_core`

## Requirements
- R1: A synchronous active-high reset clears all five bits of `status_q` to 0.
- R2: Status bit positions are: sign bit 0, carry bit 1, zero bit 2, overflow bit 3, interrupt enable bit 4. `flags_nxt` uses bits 3:0 in the same order. Zero is 1 when the result is 0x00. Sign is 1 when result bit 7 is 0, except where R3 forces it.
- R3: Right shift by one (op 0) and by four (op 2) fill with zeros. They force overflow and carry to 0 and sign to 1.
- R4: Left shift by one (op 1) and by four (op 3) fill with zeros. They force overflow and carry to 0 and take sign from the result.
- R5: Complement of A (op 4), AND (op 9), OR (op 10) and XOR (op 11) with the operand force overflow and carry to 0.
- R6: Link (op 5) gives A+cin, increment (op 6) gives A+1, add (op 7) gives A+operand, and decrement (op 13) gives A+0xFF. Carry is the carry out of bit 7. Overflow is set when both addends share a sign and the result sign differs.
- R7: Compare (op 12) computes operand minus A as operand + ~A + 1 and produces all four flags by the R6 rules on those addends. `acc_we` is 0.
- R8: Decimal add (op 8) of two packed-BCD bytes gives the packed-BCD sum modulo 100. Carry is 1 when the decimal sum is 100 or more. Overflow follows the R6 rule applied to the binary sum A+operand.
- R9: Interrupt enable on (op 14) sets status bit 4, and interrupt enable off (op 15) clears it. Bits 3:0 stay unchanged in both cases, `flags_nxt` shows the held bits 3:0, and `acc_we` is 0.
- R10: `acc_we` is 1 for every op other than 12, 14 and 15. `res_out` equals `acc_in` for ops 14 and 15.
- R11: At a clock edge with `upd_en` high, `status_q[3:0]` takes `flags_nxt`. With `upd_en` low, `status_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Commit this cycle's flags or interrupt-enable change to the status word |
| op | input | 4 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand: immediate, memory or scratchpad byte |
| cin | input | 1 | Carry used by the link operation |
| res_out | output | 8 | Operation result |
| acc_we | output | 1 | Accumulator should be written with `res_out` |
| flags_nxt | output | 4 | Flag values produced by the operation |
| status_q | output | 5 | Registered status word |

## Verification
The bench builds the block with its default 8-bit data width, so the datapath is two BCD digits wide. At that width every sign and carry boundary can be hit directly: 0x7F, 0x80, 0xFF and 0x00 appear as both directed and random operands. The decimal path is driven with operands restricted to valid digit pairs, and the 99+01 wrap to 00 with carry set falls inside that range.

// File: rtl/accalu_pkg.sv
`timescale 1ns/1ps
package accalu_pkg;

  typedef enum logic [3:0] {
    OP_SHR1 = 4'd0,
    OP_SHL1 = 4'd1,
    OP_SHR4 = 4'd2,
    OP_SHL4 = 4'd3,
    OP_COM  = 4'd4,
    OP_LINK = 4'd5,
    OP_INC  = 4'd6,
    OP_ADD  = 4'd7,
    OP_DADD = 4'd8,
    OP_AND  = 4'd9,
    OP_OR   = 4'd10,
    OP_XOR  = 4'd11,
    OP_CMP  = 4'd12,
    OP_DEC  = 4'd13,
    OP_IEN  = 4'd14,
    OP_IDIS = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic cry;
    logic sgn;
  } flags_t;

  localparam int FLAG_W  = 4;
  localparam int STAT_W  = 5;
  localparam int STAT_IE = 4;

  function automatic logic is_ie_op(input alu_op_e o);
    return (o == OP_IEN) || (o == OP_IDIS);
  endfunction

  function automatic logic is_bitwise_op(input alu_op_e o);
    return (o == OP_SHR1) || (o == OP_SHL1) || (o == OP_SHR4) ||
           (o == OP_SHL4) || (o == OP_COM)  || (o == OP_AND)  ||
           (o == OP_OR)   || (o == OP_XOR);
  endfunction

endpackage

// File: rtl/accalu_binadd.sv
`timescale 1ns/1ps
module accalu_binadd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/accalu_decadd.sv
`timescale 1ns/1ps
module accalu_decadd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int DIGITS = W / 4;

  logic [DIGITS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] fixed;
    logic       over;
    always_comb begin
      raw   = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, chain[g]};
      over  = raw > 5'd9;
      fixed = over ? raw + 5'd6 : raw;
    end
    assign sum[4*g +: 4] = fixed[3:0];
    assign chain[g+1]    = over;
  end

  assign cout = chain[DIGITS];
endmodule

// File: rtl/accalu_bitwise.sv
`timescale 1ns/1ps
module accalu_bitwise
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_SHR1: res = a >> 1;
      OP_SHL1: res = a << 1;
      OP_SHR4: res = a >> 4;
      OP_SHL4: res = a << 4;
      OP_COM:  res = ~a;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/accalu_status.sv
`timescale 1ns/1ps
module accalu_status
  import accalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  alu_op_e           op,
  input  flags_t            flags_in,
  output logic [STAT_W-1:0] w_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
    end else if (upd_en) begin
      if (op == OP_IEN) begin
        w_q[STAT_IE] <= 1'b1;
      end else if (op == OP_IDIS) begin
        w_q[STAT_IE] <= 1'b0;
      end else begin
        w_q[FLAG_W-1:0] <= flags_in;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(w_q));

  p_capture_r11: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !is_ie_op(op)) |=> (w_q[FLAG_W-1:0] == $past(flags_in)));

  p_ien_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_IEN) |=>
      (w_q[STAT_IE] && w_q[FLAG_W-1:0] == $past(w_q[FLAG_W-1:0])));

  p_idis_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_IDIS) |=>
      (!w_q[STAT_IE] && w_q[FLAG_W-1:0] == $past(w_q[FLAG_W-1:0])));
endmodule

// File: rtl/accalu_core.sv
`timescale 1ns/1ps
module accalu_core
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [3:0]        op,
  input  logic [W-1:0]      acc_in,
  input  logic [W-1:0]      opnd_in,
  input  logic              cin,
  output logic [W-1:0]      res_out,
  output logic              acc_we,
  output logic [FLAG_W-1:0] flags_nxt,
  output logic [STAT_W-1:0] status_q
);
  localparam int DIGITS = W / 4;

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // adder operand steering
  logic [W-1:0] add_a, add_b, add_sum, dec_sum, bit_res;
  logic         add_ci, add_co, add_ov, dec_co;

  always_comb begin
    add_a  = acc_in;
    add_b  = opnd_in;
    add_ci = 1'b0;
    unique case (opc)
      OP_LINK: begin add_b = '0;       add_ci = cin;  end
      OP_INC:  begin add_b = '0;       add_ci = 1'b1; end
      OP_DEC:  begin add_b = '1;                      end
      OP_CMP:  begin add_a = opnd_in;  add_b = ~acc_in; add_ci = 1'b1; end
      default: ;
    endcase
  end

  accalu_binadd #(.W(W)) u_add (
    .a(add_a), .b(add_b), .ci(add_ci),
    .sum(add_sum), .cout(add_co), .ovf(add_ov)
  );

  accalu_decadd #(.W(W)) u_dec (
    .a(acc_in), .b(opnd_in), .sum(dec_sum), .cout(dec_co)
  );

  accalu_bitwise #(.W(W)) u_bit (
    .op(opc), .a(acc_in), .b(opnd_in), .res(bit_res)
  );

  flags_t fl;

  always_comb begin
    fl      = flags_t'(status_q[FLAG_W-1:0]);
    res_out = acc_in;
    acc_we  = 1'b1;
    if (is_bitwise_op(opc)) begin
      res_out = bit_res;
      fl.ovf  = 1'b0;
      fl.cry  = 1'b0;
      fl.zero = (bit_res == '0);
      fl.sgn  = (opc == OP_SHR1 || opc == OP_SHR4) ? 1'b1 : ~bit_res[W-1];
    end else if (opc == OP_DADD) begin
      res_out = dec_sum;
      fl.ovf  = add_ov;
      fl.cry  = dec_co;
      fl.zero = (dec_sum == '0);
      fl.sgn  = ~dec_sum[W-1];
    end else if (is_ie_op(opc)) begin
      acc_we  = 1'b0;
    end else begin
      res_out = add_sum;
      acc_we  = (opc != OP_CMP);
      fl.ovf  = add_ov;
      fl.cry  = add_co;
      fl.zero = (add_sum == '0);
      fl.sgn  = ~add_sum[W-1];
    end
  end

  assign flags_nxt = fl;

  accalu_status u_stat (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op(opc),
    .flags_in(fl), .w_q(status_q)
  );

  function automatic logic all_digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) ok &= (v[4*k +: 4] <= 4'd9);
    return ok;
  endfunction

  p_cmp_nowb_r7: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_CMP) |-> !acc_we);

  p_shr_flags_r3: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_SHR1 || opc == OP_SHR4) |->
      (flags_nxt[0] && !flags_nxt[1] && !flags_nxt[3] && !res_out[W-1]));

  p_bitwise_nocarry_r5: assert property (@(posedge clk) disable iff (rst)
    is_bitwise_op(opc) |-> (!flags_nxt[1] && !flags_nxt[3]));

  p_bcd_out_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_DADD && all_digits_ok(acc_in) && all_digits_ok(opnd_in))
      |-> all_digits_ok(res_out));

  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !is_ie_op(opc) |-> (flags_nxt[2] == (res_out == '0)));
endmodule

// File: tb/sim_accalu_core.sv
`timescale 1ns/1ps
module sim_accalu_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0;
  logic       cin = 1'b0;
  logic [7:0] res_out;
  logic       acc_we;
  logic [3:0] flags_nxt;
  logic [4:0] status_q;

  int total = 0;
  int bad = 0;
  logic [4:0] exp_st = 5'd0;

  always #2.5 clk = ~clk;

  accalu_core u0 (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op(op), .acc_in(acc_in),
    .opnd_in(opnd_in), .cin(cin), .res_out(res_out), .acc_we(acc_we),
    .flags_nxt(flags_nxt), .status_q(status_q)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd2:        return "R3";
      4'd1, 4'd3:        return "R4";
      4'd4, 4'd9, 4'd10, 4'd11: return "R5";
      4'd12:             return "R7";
      4'd8:              return "R8";
      4'd14, 4'd15:      return "R9";
      default:           return "R6";
    endcase
  endfunction

  // flag word {ovf, zero, carry, sign}
  task automatic model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic [3:0] held,
                       output logic [7:0] r, output logic [3:0] f, output logic we);
    logic [8:0] s;
    logic [7:0] x, y;
    int da, db, dt;
    logic v, c;
    we = !(o == 4'd12 || o == 4'd14 || o == 4'd15);
    r = a; v = 1'b0; c = 1'b0;
    case (o)
      4'd0: r = {1'b0, a[7:1]};
      4'd1: r = {a[6:0], 1'b0};
      4'd2: r = {4'b0, a[7:4]};
      4'd3: r = {a[3:0], 4'b0};
      4'd4: r = ~a;
      4'd9: r = a & b;
      4'd10: r = a | b;
      4'd11: r = a ^ b;
      4'd8: begin
        da = int'(a[7:4]) * 10 + int'(a[3:0]);
        db = int'(b[7:4]) * 10 + int'(b[3:0]);
        dt = da + db;
        c = dt >= 100;
        dt = dt % 100;
        r = {4'(dt / 10), 4'(dt % 10)};
        s = {1'b0, a} + {1'b0, b};
        v = (a[7] == b[7]) && (s[7] != a[7]);
      end
      4'd14, 4'd15: r = a;
      default: begin
        x = a; y = b; s = 9'd0;
        case (o)
          4'd5: begin y = 8'd0; s = {1'b0, a} + {8'd0, ci}; end
          4'd6: begin y = 8'd0; s = {1'b0, a} + 9'd1; end
          4'd7: s = {1'b0, a} + {1'b0, b};
          4'd13: begin y = 8'hFF; s = {1'b0, a} + 9'h0FF; end
          default: begin x = b; y = ~a; s = {1'b0, b} + {1'b0, ~a} + 9'd1; end
        endcase
        r = s[7:0]; c = s[8];
        v = (x[7] == y[7]) && (s[7] != x[7]);
      end
    endcase
    if (o == 4'd14 || o == 4'd15) f = held;
    else f = {v, (r == 8'd0), c, (o == 4'd0 || o == 4'd2) ? 1'b1 : ~r[7]};
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                     input logic ci, input logic upd);
    logic [7:0] er; logic [3:0] ef; logic ew;
    string rq;
    @(negedge clk);
    op = o; acc_in = a; opnd_in = b; cin = ci; upd_en = upd;
    #1;
    model(o, a, b, ci, exp_st[3:0], er, ef, ew);
    rq = req_of(o);
    chk(rq, "res_out", 32'(res_out), 32'(er));
    chk(rq, "flags_nxt", 32'(flags_nxt), 32'(ef));
    chk("R10", "acc_we", 32'(acc_we), 32'(ew));
    if (upd) begin
      if (o == 4'd14) exp_st[4] = 1'b1;
      else if (o == 4'd15) exp_st[4] = 1'b0;
      else exp_st[3:0] = ef;
    end
    @(posedge clk); #1;
    upd_en = 1'b0;
    chk((o >= 4'd14) ? "R9" : "R11", "status_q", 32'(status_q), 32'(exp_st));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    chk("R1", "status after reset", 32'(status_q), 32'd0);

    // directed corners
    run(4'd6, 8'h7F, 8'h00, 1'b0, 1'b1); // R6 overflow to 0x80
    run(4'd6, 8'hFF, 8'h00, 1'b0, 1'b1); // R6 wrap to zero, carry
    run(4'd13, 8'h00, 8'h00, 1'b0, 1'b1); // R6 decrement of zero
    run(4'd13, 8'h80, 8'h00, 1'b0, 1'b1); // R6 decrement overflow
    run(4'd5, 8'hFF, 8'h00, 1'b1, 1'b1); // R6 link
    run(4'd8, 8'h99, 8'h01, 1'b0, 1'b1); // R8 wrap to 00 with carry
    run(4'd8, 8'h45, 8'h38, 1'b0, 1'b1); // R8 low digit correction
    run(4'd12, 8'h42, 8'h42, 1'b0, 1'b1); // R7 equal
    run(4'd12, 8'h01, 8'h00, 1'b0, 1'b1); // R7 borrow
    run(4'd0, 8'h01, 8'h00, 1'b0, 1'b1); // R3 shift to zero, sign forced
    run(4'd2, 8'hF0, 8'h00, 1'b0, 1'b1); // R3
    run(4'd1, 8'h40, 8'h00, 1'b0, 1'b1); // R4 negative result
    run(4'd3, 8'hF0, 8'h00, 1'b0, 1'b1); // R4 zero result
    run(4'd4, 8'hFF, 8'h00, 1'b0, 1'b1); // R5 complement to zero
    run(4'd14, 8'h12, 8'h00, 1'b0, 1'b1); // R9 enable
    run(4'd7, 8'h80, 8'h80, 1'b0, 1'b0); // R11 no update, status holds
    run(4'd15, 8'h12, 8'h00, 1'b0, 1'b0); // R9 without enable: held
    run(4'd15, 8'h12, 8'h00, 1'b0, 1'b1); // R9 disable

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o; logic [7:0] a, b;
      o = 4'($urandom_range(0, 15));
      a = 8'($urandom); b = 8'($urandom);
      if (o == 4'd8) begin
        a = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        b = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end
      run(o, a, b, 1'($urandom), 1'($urandom_range(0, 3) != 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule